// File: doc/BRIEF.md
# Indirect Jump Target Guard

This block sits next to the retirement stage of a 32-bit integer core and enforces forward-edge control flow integrity. For every retiring instruction it observes the decoded class (register-indirect jump or add-upper-immediate-to-PC), the destination and first source register numbers, the 20-bit upper immediate, the two low bits of the instruction address, and the upper 20 bits of register x7. The core supplies these on the cycle the instruction retires.

When protection is enabled and an indirect jump retires through a register that is not exempt, the guard records that the next retired instruction must be a valid target marker. A target marker is an add-upper-immediate-to-PC instruction whose destination is x0. Its immediate is a label: zero means "accept any caller", and any other value must equal x7 bits [31:12]. Jumps through x1 or x5 (returns) and through x7 (compiler-built, software-guarded jumps) are exempt. A missing marker, a marker at an address that is not 4-byte aligned, or a label mismatch produces a one-cycle exception request with cause 18 and trap value 2. The request is registered, so it appears the cycle after the offending instruction retires.

Top module: `jmp_target_guard`

## Requirements
- R1: After synchronous active-high reset, `excReq` is 0, `excCause` and `excTval` are 0, and no expectation is pending.
- R2: With `enable` high, a retired jump (`retIsJalr`=1) whose `retRs1` is not 1, 5 or 7 arms an expectation. If the next retired instruction is not a marker (`retIsAuipc`=1 and `retRd`=0), `excReq` is 1 in the cycle after that instruction retires.
- R3: A jump with `retRs1` equal to 1 or 5 arms nothing. An ordinary instruction after it raises no request.
- R4: A jump with `retRs1` equal to 7 arms nothing. An ordinary instruction after it raises no request.
- R5: A marker with immediate 0 at an aligned address (`retPcLo`=0) satisfies a pending expectation for any `regX7Hi`, and it clears the expectation.
- R6: A marker retired while an expectation is pending, with `retPcLo` nonzero, raises a request.
- R7: A marker with a nonzero immediate satisfies the expectation only if the immediate equals `regX7Hi`. Otherwise it raises a request.
- R8: While `excReq` is 1, `excCause` is 18 and `excTval` is 2. While it is 0, both are 0. Each violation produces exactly one cycle of `excReq`.
- R9: While `enable` is 0, no expectation is armed and no request is raised, even for an expectation armed earlier.
- R10: With no expectation pending, any instruction, including a misaligned or mismatching marker, raises no request.
- R11: Cycles with `retValid` low neither check nor clear a pending expectation.
- R12: `trapTaken` clears the pending expectation. An instruction reported as retiring in the same cycle as a trap is neither checked nor able to arm.
- R13: A tracked jump retiring while an expectation is pending raises a request and also arms a new expectation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Protection enable |
| retValid | input | 1 | An instruction retires this cycle |
| retIsJalr | input | 1 | Retiring instruction is a register-indirect jump |
| retIsAuipc | input | 1 | Retiring instruction is add-upper-immediate-to-PC |
| retRd | input | 5 | Destination register number |
| retRs1 | input | 5 | First source register number |
| retImm | input | 20 | Upper immediate field |
| retPcLo | input | 2 | Bits [1:0] of the retiring instruction address |
| regX7Hi | input | 20 | Bits [31:12] of register x7 |
| trapTaken | input | 1 | The core takes a trap this cycle |
| excReq | output | 1 | One-cycle software check exception request |
| excCause | output | 32 | Cause code, 18 while requesting |
| excTval | output | 32 | Trap value, 2 while requesting |

## Verification
Two functions can coincide: a pending expectation is checked, and a new one is armed, on the same retirement. The bench provokes this by retiring two tracked jumps back to back. It judges the outcome by a request after the second jump, followed by acceptance of an aligned zero-label marker on the next retirement, and by two consecutive request cycles when a third ordinary instruction follows instead. A trap arriving on the same cycle as a checked retirement is also driven, and must suppress the request.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

  localparam int unsigned SwCheckCause = 18;
  localparam int unsigned TargetTval   = 2;

  // Per-instruction classification from datapath to control
  typedef struct packed {
    logic isTracked;
    logic isMarker;
    logic misaligned;
    logic labelBad;
  } decodeInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic raise;
  } ctrlStrobe_t;

endpackage

// File: rtl/jtg_dpath.sv
module jtg_dpath
  import jtg_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned LABEL_W   = 20,
  parameter int unsigned RET_REG_A = 1,
  parameter int unsigned RET_REG_B = 5,
  parameter int unsigned GUARD_REG = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retIsJalr,
  input  logic               retIsAuipc,
  input  logic [REG_W-1:0]   retRd,
  input  logic [REG_W-1:0]   retRs1,
  input  logic [LABEL_W-1:0] retImm,
  input  logic [1:0]         retPcLo,
  input  logic [LABEL_W-1:0] regX7Hi,
  input  ctrlStrobe_t        strobe,
  output decodeInfo_t        info,
  output logic               excReq,
  output logic [XLEN-1:0]    excCause,
  output logic [XLEN-1:0]    excTval
);

  localparam logic [REG_W-1:0] RegA  = REG_W'(RET_REG_A);
  localparam logic [REG_W-1:0] RegB  = REG_W'(RET_REG_B);
  localparam logic [REG_W-1:0] RegG  = REG_W'(GUARD_REG);
  localparam logic [XLEN-1:0]  CauseVal = XLEN'(SwCheckCause);
  localparam logic [XLEN-1:0]  TvalVal  = XLEN'(TargetTval);

  logic exemptSrc;

  always_comb begin
    exemptSrc       = (retRs1 == RegA) || (retRs1 == RegB) || (retRs1 == RegG);
    info.isTracked  = retIsJalr && !exemptSrc;
    info.isMarker   = retIsAuipc && (retRd == '0);
    info.misaligned = (retPcLo != 2'b00);
    info.labelBad   = (retImm != '0) && (retImm != regX7Hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      excReq   <= 1'b0;
      excCause <= '0;
      excTval  <= '0;
    end else begin
      excReq   <= strobe.raise;
      excCause <= strobe.raise ? CauseVal : '0;
      excTval  <= strobe.raise ? TvalVal : '0;
    end
  end

  a_r8_codes_when_req: assert property (@(posedge clk) disable iff (rst)
    excReq |-> (excCause == CauseVal) && (excTval == TvalVal));

  a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !excReq |-> (excCause == '0) && (excTval == '0));

endmodule

// File: rtl/jtg_ctrl.sv
module jtg_ctrl
  import jtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        retValid,
  input  logic        trapTaken,
  input  decodeInfo_t info,
  output ctrlStrobe_t strobe,
  output logic        expectFlag
);

  logic checkNow;
  logic armNow;
  logic badTarget;

  always_comb begin
    checkNow     = enable && retValid && expectFlag && !trapTaken;
    armNow       = enable && retValid && !trapTaken && info.isTracked;
    badTarget    = !info.isMarker || info.misaligned || info.labelBad;
    strobe.raise = checkNow && badTarget;
  end

  always_ff @(posedge clk) begin
    if (rst)            expectFlag <= 1'b0;
    else if (trapTaken) expectFlag <= 1'b0;
    else if (retValid)  expectFlag <= armNow;
  end

  a_r12_trap_clears: assert property (@(posedge clk) disable iff (rst)
    trapTaken |=> !expectFlag);

  a_r9_no_arm_disabled: assert property (@(posedge clk) disable iff (rst)
    (retValid && !enable) |=> !expectFlag);

  a_r11_bubble_holds: assert property (@(posedge clk) disable iff (rst)
    (!retValid && !trapTaken) |=> $stable(expectFlag));

endmodule

// File: rtl/jmp_target_guard.sv
module jmp_target_guard
  import jtg_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned REG_W   = 5,
  parameter int unsigned LABEL_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               retValid,
  input  logic               retIsJalr,
  input  logic               retIsAuipc,
  input  logic [REG_W-1:0]   retRd,
  input  logic [REG_W-1:0]   retRs1,
  input  logic [LABEL_W-1:0] retImm,
  input  logic [1:0]         retPcLo,
  input  logic [LABEL_W-1:0] regX7Hi,
  input  logic               trapTaken,
  output logic               excReq,
  output logic [XLEN-1:0]    excCause,
  output logic [XLEN-1:0]    excTval
);

  decodeInfo_t info;
  ctrlStrobe_t strobe;
  logic        expectFlag;

  jtg_dpath #(
    .XLEN(XLEN), .REG_W(REG_W), .LABEL_W(LABEL_W)
  ) uDpath (
    .clk(clk), .rst(rst),
    .retIsJalr(retIsJalr), .retIsAuipc(retIsAuipc),
    .retRd(retRd), .retRs1(retRs1), .retImm(retImm),
    .retPcLo(retPcLo), .regX7Hi(regX7Hi),
    .strobe(strobe), .info(info),
    .excReq(excReq), .excCause(excCause), .excTval(excTval)
  );

  jtg_ctrl uCtrl (
    .clk(clk), .rst(rst), .enable(enable),
    .retValid(retValid), .trapTaken(trapTaken),
    .info(info), .strobe(strobe), .expectFlag(expectFlag)
  );

  a_r10_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    !expectFlag |=> !excReq);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !excReq);

endmodule

// File: tb/sim_jmp_target_guard.sv
`timescale 1ns/1ps
module sim_jmp_target_guard;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic        retValid;
  logic        retIsJalr;
  logic        retIsAuipc;
  logic [4:0]  retRd;
  logic [4:0]  retRs1;
  logic [19:0] retImm;
  logic [1:0]  retPcLo;
  logic [19:0] regX7Hi;
  logic        trapTaken;
  logic        excReq;
  logic [31:0] excCause;
  logic [31:0] excTval;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  jmp_target_guard u0 (
    .clk(clk), .rst(rst), .enable(enable), .retValid(retValid),
    .retIsJalr(retIsJalr), .retIsAuipc(retIsAuipc), .retRd(retRd),
    .retRs1(retRs1), .retImm(retImm), .retPcLo(retPcLo),
    .regX7Hi(regX7Hi), .trapTaken(trapTaken),
    .excReq(excReq), .excCause(excCause), .excTval(excTval)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, return just after the rising edge
  task automatic step(input logic v, input logic jalr, input logic auipc,
                      input logic [4:0] rd, input logic [4:0] rs1,
                      input logic [19:0] imm, input logic [1:0] pcLo,
                      input logic [19:0] x7, input logic trap);
    @(negedge clk);
    retValid = v; retIsJalr = jalr; retIsAuipc = auipc; retRd = rd;
    retRs1 = rs1; retImm = imm; retPcLo = pcLo; regX7Hi = x7; trapTaken = trap;
    @(posedge clk);
    #1;
  endtask

  task automatic jump(input logic [4:0] rs1);
    step(1, 1, 0, 5'd0, rs1, 20'h0, 2'b00, 20'h0, 0);
  endtask
  task automatic marker(input logic [19:0] imm, input logic [1:0] pcLo, input logic [19:0] x7);
    step(1, 0, 1, 5'd0, 5'd0, imm, pcLo, x7, 0);
  endtask
  task automatic plain();
    step(1, 0, 0, 5'd3, 5'd4, 20'h12345, 2'b00, 20'h0, 0);
  endtask
  task automatic bubble();
    step(0, 0, 0, 5'd0, 5'd0, 20'h0, 2'b00, 20'h0, 0);
  endtask

  task automatic expectReq(input string req, input logic exp);
    check(req, {31'd0, excReq}, {31'd0, exp});
    check({req, " cause"}, excCause, exp ? 32'd18 : 32'd0);
    check({req, " tval"},  excTval,  exp ? 32'd2  : 32'd0);
  endtask

  task automatic t_reset();
    rst = 1; enable = 1;
    bubble(); bubble();
    rst = 0;
    expectReq("R1 reset", 0);
    plain();
    expectReq("R1 no expectation after reset", 0);
  endtask

  task automatic t_missing();
    jump(5'd10);
    expectReq("R2 jump itself", 0);
    plain();
    expectReq("R2 missing marker", 1);
    bubble();
    expectReq("R8 single pulse", 0);
    jump(5'd0);
    step(1, 0, 1, 5'd3, 5'd0, 20'h0, 2'b00, 20'h0, 0);
    expectReq("R2 auipc with rd!=0", 1);
    bubble();
  endtask

  task automatic t_exempt();
    jump(5'd1); plain();
    expectReq("R3 rs1=x1", 0);
    jump(5'd5); plain();
    expectReq("R3 rs1=x5", 0);
    jump(5'd7); plain();
    expectReq("R4 rs1=x7", 0);
  endtask

  task automatic t_zero_label();
    jump(5'd12);
    marker(20'h0, 2'b00, 20'hFEDCB);
    expectReq("R5 zero label accepted", 0);
    plain();
    expectReq("R5 expectation cleared", 0);
  endtask

  task automatic t_misaligned();
    jump(5'd12);
    marker(20'h0, 2'b10, 20'h0);
    expectReq("R6 misaligned marker", 1);
    jump(5'd12);
    marker(20'h0, 2'b01, 20'h0);
    expectReq("R6 misaligned by one", 1);
    bubble();
  endtask

  task automatic t_label();
    jump(5'd20);
    marker(20'hABCDE, 2'b00, 20'hABCDE);
    expectReq("R7 label match", 0);
    jump(5'd20);
    marker(20'hABCDE, 2'b00, 20'hABCDF);
    expectReq("R7 label mismatch", 1);
    bubble();
  endtask

  task automatic t_disabled();
    enable = 0;
    jump(5'd9); plain();
    expectReq("R9 no arming while disabled", 0);
    enable = 1;
    jump(5'd9);
    enable = 0;
    plain();
    expectReq("R9 no check while disabled", 0);
    enable = 1;
    plain();
    expectReq("R9 stale expectation dropped", 0);
  endtask

  task automatic t_unarmed();
    marker(20'h00001, 2'b11, 20'h00002);
    expectReq("R10 marker without expectation", 0);
    plain();
    expectReq("R10 plain without expectation", 0);
  endtask

  task automatic t_bubbles();
    jump(5'd11);
    bubble();
    expectReq("R11 bubble 1", 0);
    bubble(); bubble();
    plain();
    expectReq("R11 expectation survives bubbles", 1);
    bubble();
  endtask

  task automatic t_trap();
    jump(5'd11);
    step(0, 0, 0, 5'd0, 5'd0, 20'h0, 2'b00, 20'h0, 1);
    plain();
    expectReq("R12 trap clears expectation", 0);
    jump(5'd11);
    step(1, 0, 0, 5'd3, 5'd4, 20'h0, 2'b00, 20'h0, 1);
    expectReq("R12 retire with trap not checked", 0);
    plain();
    expectReq("R12 cleared after trap retire", 0);
    step(1, 1, 0, 5'd0, 5'd11, 20'h0, 2'b00, 20'h0, 1);
    plain();
    expectReq("R12 jump with trap does not arm", 0);
  endtask

  task automatic t_chain();
    jump(5'd10);
    jump(5'd11);
    expectReq("R13 jump where marker expected", 1);
    marker(20'h0, 2'b00, 20'h0);
    expectReq("R13 re-armed then satisfied", 0);
    jump(5'd10);
    jump(5'd11);
    plain();
    expectReq("R13 second consecutive request", 1);
    bubble();
    expectReq("R13 requests end", 0);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    enable = 1; retValid = 0; retIsJalr = 0; retIsAuipc = 0; retRd = '0;
    retRs1 = '0; retImm = '0; retPcLo = '0; regX7Hi = '0; trapTaken = 0; rst = 1;
    t_reset();
    t_missing();
    t_exempt();
    t_zero_label();
    t_misaligned();
    t_label();
    t_disabled();
    t_unarmed();
    t_bubbles();
    t_trap();
    t_chain();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule